// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block steers a small accumulator-style processor into and out of interrupt handlers. Four request lines are served, line 0 being the most urgent and line 3 the least. Each line has a handler address held in a small table that the processor fills and inspects through dedicated commands. A line may fire only when its enable bit in the status word is set. When one fires, the controller saves a return address in a per-level slot and asks the processor to jump to that line's handler.

Handlers nest by strict priority. A more urgent request interrupts a running handler at once. A less urgent or equal one waits until the running handler returns. The return command jumps back to the address saved for the current level and reopens the level below it. Software can raise any line by command, and it can read and rewrite the saved return addresses. A misaligned memory access can also be routed to line 0; in that case the return address is the faulting instruction itself.

Requests are sampled only at instruction boundaries and are level-sensitive. The register file and the instruction decoder live outside this block.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset no level is active: `in_ctx_o`=0, `level_o`=0 and `redirect_o`=0, and every handler and saved-address entry reads back 0.
- R2: Commands on `cmd_op_i` use these codes: 0 none, 1 set-handler, 2 get-handler, 3 set-saved, 4 get-saved, 5 software trigger. Set-handler stores `wr_data_i` as the handler of line `cmd_idx_i`. Get-handler shows that handler on `rd_data_o` in the same cycle. `rd_data_o` is 0 for the codes that do not read.
- R3: Status bit k+1 (`stat_i[k+1]`) enables line k. A request on a disabled line never causes a redirect.
- R4: At a boundary with an eligible line k, `redirect_o`=1 and `redirect_pc_o` equals line k's handler in the same cycle, and `next_pc_i` is saved in slot k. From the next cycle on, `in_ctx_o`=1 and `level_o`=k.
- R5: When several eligible lines request at one boundary, the lowest-numbered one is taken.
- R6: While level L is active, a request on a line below L is taken at the next boundary. A request on line L or above it stays pending and causes no redirect.
- R7: A return while in context gives `redirect_o`=1 and `redirect_pc_o` equal to the slot of the current level in the same cycle. From the next cycle that level is inactive, and `level_o` shows the next less urgent active level, or `in_ctx_o`=0 if none remains.
- R8: A return with no active level is ignored: no redirect, and the state is unchanged.
- R9: A software trigger on line k stays pending until line k is taken. It obeys the enable of line k, and it is cleared once taken.
- R10: With `stat_i[5]`=1, `misalign_i`=1 at a boundary raises line 0, and the saved address is `insn_pc_i` rather than `next_pc_i`. With `stat_i[5]`=0 the misalignment raises nothing.
- R11: A line still requesting after its handler returns is taken again at the next boundary.
- R12: Set-saved writes `wr_data_i` into slot `cmd_idx_i`. Get-saved shows that slot on `rd_data_o`, and a later return from that level uses the written value.
- R13: No redirect occurs in a cycle with neither a boundary nor a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 4 | Level request lines, bit 0 most urgent |
| stat_i | input | 5 | Status bits 5..1: line enables on 1..4, misalignment trap enable on 5 |
| misalign_i | input | 1 | The current instruction made a misaligned access |
| insn_boundary_i | input | 1 | An instruction completes; requests are sampled |
| next_pc_i | input | 16 | Address of the next instruction |
| insn_pc_i | input | 16 | Address of the current instruction |
| wr_data_i | input | 16 | Working-register value for the set commands |
| cmd_op_i | input | 3 | Command code |
| cmd_idx_i | input | 2 | Line or slot index of the command |
| ret_i | input | 1 | Return-from-handler strobe |
| redirect_o | output | 1 | Program counter must be loaded this cycle |
| redirect_pc_o | output | 16 | Address to load |
| in_ctx_o | output | 1 | At least one level is active |
| level_o | output | 2 | Most urgent active level |
| rd_data_o | output | 16 | Result of the get commands |

## Verification
The redirect, its target and the read data are combinational, so they are due in the same cycle as the boundary, return or get command that causes them. The bench drives each stimulus just after a falling edge and its monitor compares these outputs a few nanoseconds later, before the next rising edge. The active level and the in-context flag change at that rising edge. Their expectations are therefore queued with the stimulus of the following cycle and compared in that cycle's sampling window.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
   typedef enum logic [2:0] {
      OP_NONE    = 3'd0,
      OP_SET_VEC = 3'd1,
      OP_GET_VEC = 3'd2,
      OP_SET_STK = 3'd3,
      OP_GET_STK = 3'd4,
      OP_SOFT    = 3'd5
   } irq_op_e;
endpackage

// File: rtl/irq_addr_file.sv
module irq_addr_file #(
   parameter int ENTRIES = 4,
   parameter int WIDTH   = 16,
   localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wa_en,
   input  logic [IW-1:0]    wa_idx,
   input  logic [WIDTH-1:0] wa_data,
   input  logic             wb_en,
   input  logic [IW-1:0]    wb_idx,
   input  logic [WIDTH-1:0] wb_data,
   input  logic [IW-1:0]    ra_idx,
   output logic [WIDTH-1:0] ra_data,
   input  logic [IW-1:0]    rb_idx,
   output logic [WIDTH-1:0] rb_data
);
   logic [WIDTH-1:0] slot_q [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      // port a outranks port b on a collision
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q[i] <= '0;
         else if (wa_en && (wa_idx == IW'(i)))
            slot_q[i] <= wa_data;
         else if (wb_en && (wb_idx == IW'(i)))
            slot_q[i] <= wb_data;
      end
   end

   assign ra_data = slot_q[ra_idx];
   assign rb_data = slot_q[rb_idx];
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int k = N - 1; k >= 0; k--)
         if (req[k]) idx = IW'(k);
   end
   assign any = |req;
endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
   parameter int N            = 4,
   parameter bit TRAP_SUPPORT = 1'b1
) (
   input  logic [N-1:0] ext_req,
   input  logic [N-1:0] soft_req,
   input  logic [N-1:0] enable,
   input  logic         trap_en,
   input  logic         misalign,
   input  logic [N-1:0] active,
   output logic         trap_hit,
   output logic [N-1:0] eligible
);
   logic [N-1:0] trap_vec;
   logic [N-1:0] above_ok;

   if (TRAP_SUPPORT) begin : g_trap
      assign trap_hit = trap_en & misalign;
      assign trap_vec = {{(N-1){1'b0}}, trap_hit};
   end else begin : g_no_trap
      assign trap_hit = 1'b0;
      assign trap_vec = '0;
      logic unused_trap;
      assign unused_trap = trap_en ^ misalign;
   end

   // a line may preempt only if no level at or above its urgency is active
   for (genvar k = 0; k < N; k++) begin : g_mask
      assign above_ok[k] = ~|active[k:0];
   end

   assign eligible = (ext_req | soft_req | trap_vec) & enable & above_ok;
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
   import irq_nest_pkg::*;
#(
   parameter int N            = 4,
   parameter int ADDR_W       = 16,
   parameter bit TRAP_SUPPORT = 1'b1,
   localparam int IW          = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      irq_req_i,
   input  logic [N+1:1]      stat_i,
   input  logic              misalign_i,
   input  logic              insn_boundary_i,
   input  logic [ADDR_W-1:0] next_pc_i,
   input  logic [ADDR_W-1:0] insn_pc_i,
   input  logic [ADDR_W-1:0] wr_data_i,
   input  logic [2:0]        cmd_op_i,
   input  logic [IW-1:0]     cmd_idx_i,
   input  logic              ret_i,
   output logic              redirect_o,
   output logic [ADDR_W-1:0] redirect_pc_o,
   output logic              in_ctx_o,
   output logic [IW-1:0]     level_o,
   output logic [ADDR_W-1:0] rd_data_o
);
   if (N < 2) begin : g_bad_n
      $error("irq_nest_ctrl: N must be at least 2");
   end
   if (ADDR_W < 2) begin : g_bad_w
      $error("irq_nest_ctrl: ADDR_W must be at least 2");
   end

   irq_op_e op;
   assign op = irq_op_e'(cmd_op_i);

   logic [N-1:0] active_q, active_d;
   logic [N-1:0] soft_q, soft_d;
   logic [N-1:0] eligible;
   logic         trap_hit;
   logic         cur_any, take_any;
   logic [IW-1:0] cur_lvl, take_idx;
   logic         do_ret, do_take;
   logic [ADDR_W-1:0] save_pc;
   logic [ADDR_W-1:0] vec_rd, vec_take, stk_rd, stk_cur;

   irq_prio_pick #(.N(N)) u_cur_pick (
      .req (active_q),
      .any (cur_any),
      .idx (cur_lvl)
   );

   irq_req_gate #(.N(N), .TRAP_SUPPORT(TRAP_SUPPORT)) u_gate (
      .ext_req  (irq_req_i),
      .soft_req (soft_q),
      .enable   (stat_i[N:1]),
      .trap_en  (stat_i[N+1]),
      .misalign (misalign_i),
      .active   (active_q),
      .trap_hit (trap_hit),
      .eligible (eligible)
   );

   irq_prio_pick #(.N(N)) u_take_pick (
      .req (eligible),
      .any (take_any),
      .idx (take_idx)
   );

   assign do_ret  = ret_i & cur_any;
   assign do_take = insn_boundary_i & take_any & ~do_ret;
   assign save_pc = (trap_hit && take_idx == '0) ? insn_pc_i : next_pc_i;

   irq_addr_file #(.ENTRIES(N), .WIDTH(ADDR_W)) u_vec_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .wa_en   (op == OP_SET_VEC),
      .wa_idx  (cmd_idx_i),
      .wa_data (wr_data_i),
      .wb_en   (1'b0),
      .wb_idx  ('0),
      .wb_data ('0),
      .ra_idx  (cmd_idx_i),
      .ra_data (vec_rd),
      .rb_idx  (take_idx),
      .rb_data (vec_take)
   );

   irq_addr_file #(.ENTRIES(N), .WIDTH(ADDR_W)) u_save_stk (
      .clk     (clk),
      .rst_n   (rst_n),
      .wa_en   (do_take),
      .wa_idx  (take_idx),
      .wa_data (save_pc),
      .wb_en   (op == OP_SET_STK),
      .wb_idx  (cmd_idx_i),
      .wb_data (wr_data_i),
      .ra_idx  (cmd_idx_i),
      .ra_data (stk_rd),
      .rb_idx  (cur_lvl),
      .rb_data (stk_cur)
   );

   always_comb begin
      active_d = active_q;
      soft_d   = soft_q;
      if (do_ret)  active_d[cur_lvl] = 1'b0;
      if (do_take) begin
         active_d[take_idx] = 1'b1;
         soft_d[take_idx]   = 1'b0;
      end
      if (op == OP_SOFT) soft_d[cmd_idx_i] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= '0;
         soft_q   <= '0;
      end else begin
         active_q <= active_d;
         soft_q   <= soft_d;
      end
   end

   always_comb begin
      unique case (op)
         OP_GET_VEC: rd_data_o = vec_rd;
         OP_GET_STK: rd_data_o = stk_rd;
         default:    rd_data_o = '0;
      endcase
   end

   assign redirect_o    = do_ret | do_take;
   assign redirect_pc_o = do_ret ? stk_cur : vec_take;
   assign in_ctx_o      = cur_any;
   assign level_o       = cur_lvl;
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
   parameter int IW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          insn_boundary_i,
   input logic          ret_i,
   input logic          redirect_o,
   input logic          in_ctx_o,
   input logic [IW-1:0] level_o
);
   a_r4_entry_sets_ctx: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o && !ret_i |=> in_ctx_o);

   a_r6_preempt_deeper: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o && !ret_i && in_ctx_o |=> in_ctx_o && (level_o < $past(level_o)));

   a_r7_return_unwinds: assert property (@(posedge clk) disable iff (!rst_n)
      ret_i && in_ctx_o |=> !in_ctx_o || (level_o > $past(level_o)));

   a_r8_idle_return: assert property (@(posedge clk) disable iff (!rst_n)
      ret_i && !in_ctx_o && !insn_boundary_i |-> !redirect_o);

   a_r13_no_stray_jump: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_boundary_i && !ret_i |-> !redirect_o);

   a_r7_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect_o |=> $stable(level_o) && $stable(in_ctx_o));
endmodule

bind irq_nest_ctrl irq_nest_chk #(.IW(IW)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .insn_boundary_i (insn_boundary_i),
   .ret_i           (ret_i),
   .redirect_o      (redirect_o),
   .in_ctx_o        (in_ctx_o),
   .level_o         (level_o)
);

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
   localparam int SEL_RED = 0, SEL_PC = 1, SEL_CTX = 2, SEL_LVL = 3, SEL_RD = 4;
   localparam logic [2:0] C_NONE = 3'd0, C_SETV = 3'd1, C_GETV = 3'd2,
                          C_SETS = 3'd3, C_GETS = 3'd4, C_SOFT = 3'd5;

   typedef struct {
      string req;
      int    sel;
      int    val;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  irq_req = '0;
   logic [5:1]  stat = '0;
   logic        misal = 1'b0;
   logic        bnd = 1'b0;
   logic [15:0] npc = '0, ipc = '0, wd = '0;
   logic [2:0]  op = '0;
   logic [1:0]  idx = '0;
   logic        rt = 1'b0;
   logic        redirect;
   logic [15:0] redirect_pc, rd_data;
   logic        in_ctx;
   logic [1:0]  level;

   logic [3:0]  nx_req = '0;
   logic [5:1]  nx_stat = '0;

   exp_t q[$];
   int   n_chk = 0, n_fail = 0;
   bit   done = 0;

   always #4 clk = ~clk;

   irq_nest_ctrl dut (
      .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .stat_i(stat),
      .misalign_i(misal), .insn_boundary_i(bnd), .next_pc_i(npc),
      .insn_pc_i(ipc), .wr_data_i(wd), .cmd_op_i(op), .cmd_idx_i(idx),
      .ret_i(rt), .redirect_o(redirect), .redirect_pc_o(redirect_pc),
      .in_ctx_o(in_ctx), .level_o(level), .rd_data_o(rd_data)
   );

   task automatic cyc(input logic b, input logic r, input logic [2:0] o,
                      input logic [1:0] i, input logic [15:0] w,
                      input logic [15:0] n, input logic [15:0] p, input logic m);
      @(negedge clk);
      irq_req = nx_req; stat = nx_stat;
      bnd = b; rt = r; op = o; idx = i; wd = w; npc = n; ipc = p; misal = m;
   endtask

   task automatic idle();                    cyc(0, 0, C_NONE, 0, 0, 0, 0, 0); endtask
   task automatic bound(input logic [15:0] n); cyc(1, 0, C_NONE, 0, 0, n, n, 0); endtask
   task automatic retc();                    cyc(0, 1, C_NONE, 0, 0, 0, 0, 0); endtask
   task automatic cmd(input logic [2:0] o, input logic [1:0] i, input logic [15:0] w);
      cyc(0, 0, o, i, w, 0, 0, 0);
   endtask

   task automatic expect_out(input string r, input int s, input int v);
      exp_t e;
      e.req = r; e.sel = s; e.val = v;
      q.push_back(e);
   endtask

   // monitor: compares queued expectations inside the current cycle
   initial begin
      forever begin
         @(negedge clk);
         #3;
         while (q.size() > 0) begin
            exp_t e;
            int act;
            e = q.pop_front();
            case (e.sel)
               SEL_RED: act = int'(redirect);
               SEL_PC:  act = int'(redirect_pc);
               SEL_CTX: act = int'(in_ctx);
               SEL_LVL: act = int'(level);
               default: act = int'(rd_data);
            endcase
            n_chk++;
            if (act != e.val) begin
               n_fail++;
               $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", e.req, e.sel, act, e.val);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R13 watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(); expect_out("R1", SEL_CTX, 0); expect_out("R1", SEL_LVL, 0); expect_out("R1", SEL_RED, 0);
      cmd(C_GETV, 3, 0); expect_out("R1", SEL_RD, 0);
      cmd(C_GETS, 1, 0); expect_out("R1", SEL_RD, 0);
      for (int i = 0; i < 4; i++) cmd(C_SETV, 2'(i), 16'(256 * (i + 1)));
      cmd(C_GETV, 2, 0); expect_out("R2", SEL_RD, 'h300);
      cmd(C_GETV, 0, 0); expect_out("R2", SEL_RD, 'h100);
      idle(); expect_out("R2", SEL_RD, 0);

      nx_req = 4'b0100; nx_stat = 5'b00000;
      bound('h50); expect_out("R3", SEL_RED, 0);
      idle(); expect_out("R3", SEL_CTX, 0);

      nx_stat = 5'b01111;
      bound('h50); expect_out("R4", SEL_RED, 1); expect_out("R4", SEL_PC, 'h300);
      cmd(C_GETS, 2, 0); expect_out("R4", SEL_CTX, 1); expect_out("R4", SEL_LVL, 2);
      expect_out("R4", SEL_RD, 'h50);

      nx_req = 4'b1100;
      bound('h58); expect_out("R6", SEL_RED, 0);
      nx_req = 4'b1110;
      bound('h60); expect_out("R6", SEL_RED, 1); expect_out("R6", SEL_PC, 'h200);
      idle(); expect_out("R6", SEL_LVL, 1); expect_out("R6", SEL_CTX, 1);

      nx_req = 4'b1100;
      retc(); expect_out("R7", SEL_RED, 1); expect_out("R7", SEL_PC, 'h60);
      idle(); expect_out("R7", SEL_LVL, 2); expect_out("R7", SEL_CTX, 1);

      cmd(C_SETS, 2, 'h77);
      cmd(C_GETS, 2, 0); expect_out("R12", SEL_RD, 'h77);
      retc(); expect_out("R12", SEL_RED, 1); expect_out("R12", SEL_PC, 'h77);
      idle(); expect_out("R7", SEL_CTX, 0);

      bound('h80); expect_out("R5", SEL_RED, 1); expect_out("R5", SEL_PC, 'h300);
      nx_req = 4'b1000;
      idle(); expect_out("R5", SEL_LVL, 2);
      retc(); expect_out("R7", SEL_PC, 'h80);
      bound('h90); expect_out("R11", SEL_RED, 1); expect_out("R11", SEL_PC, 'h400);
      nx_req = 4'b0000;
      idle(); expect_out("R11", SEL_LVL, 3);
      retc(); expect_out("R7", SEL_PC, 'h90);
      idle(); expect_out("R7", SEL_CTX, 0);

      retc(); expect_out("R8", SEL_RED, 0);
      idle(); expect_out("R8", SEL_CTX, 0); expect_out("R8", SEL_LVL, 0);

      nx_stat = 5'b01101;
      cmd(C_SOFT, 1, 0);
      bound('hA0); expect_out("R9", SEL_RED, 0);
      nx_stat = 5'b01111;
      bound('hA0); expect_out("R9", SEL_RED, 1); expect_out("R9", SEL_PC, 'h200);
      retc(); expect_out("R9", SEL_PC, 'hA0);
      bound('hA8); expect_out("R9", SEL_RED, 0);

      nx_stat = 5'b11111;
      cyc(1, 0, C_NONE, 0, 0, 'hB4, 'hB3, 1); expect_out("R10", SEL_RED, 1); expect_out("R10", SEL_PC, 'h100);
      cmd(C_GETS, 0, 0); expect_out("R10", SEL_RD, 'hB3); expect_out("R10", SEL_LVL, 0);
      expect_out("R10", SEL_CTX, 1);
      retc(); expect_out("R10", SEL_PC, 'hB3);
      nx_stat = 5'b01111;
      cyc(1, 0, C_NONE, 0, 0, 'hB4, 'hB3, 1); expect_out("R10", SEL_RED, 0);

      nx_req = 4'b0001;
      idle(); expect_out("R13", SEL_RED, 0);
      bound('hC0); expect_out("R4", SEL_PC, 'h100);
      nx_req = 4'b0000;
      retc(); expect_out("R7", SEL_PC, 'hC0);
      idle(); expect_out("R7", SEL_CTX, 0);
      idle();
      idle();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule